// File: doc/BRIEF.md
# NMI Source Latch and Gate

This block gathers non-maskable interrupt requests from three error sources, namely a memory parity checker, an active-low expansion-bus channel-check line, and the interrupt line of a numeric coprocessor. It drives one registered NMI line toward the processor. The parity and channel-check requests are held in sticky latches. Each latch reports its state on a status output, which a parallel-port status register reads. The coprocessor request is not latched and follows its synchronised input line.

One enable bit gates the NMI line. Software sets or clears this bit with a write to a single I/O address through a small bus-slave decoder. The bit gates only the output. The latches keep capturing while NMI is disabled, so enabling with a request already pending raises NMI at once. Software clears a latch by taking its enable input from a control register low and then high again. Neither the processor taking the interrupt nor the source going idle clears a latch.

Top module: `nmi_src_gate`

## Requirements
- R1: After reset the NMI output is 0, both status outputs are 0 and the delivery enable is 0.
- R2: A write strobe with address 0xA0 loads data bit 7 into the delivery enable on the next clock (1 enables, 0 disables). Data bits 6..0 have no effect, so writing 0x7F disables delivery and writing 0xFF enables it.
- R3: A write strobe with any other address leaves the delivery enable unchanged.
- R4: A parity error sampled high while the parity enable is 1 sets the parity latch one clock later, and the latch stays set after the source drops. It is shown on the parity status output, which feeds status bit 7.
- R5: The channel-check input is active low and passes through two flip-flops before it is captured. A low level applied before clock edge k sets the channel latch after edge k+2. The latch is sticky and is shown on the channel status output, which feeds status bit 6.
- R6: The latches capture while delivery is disabled and the NMI output stays 0 in that state. When a latch is already set, enabling delivery raises NMI one clock after the enable bit updates.
- R7: While a latch's enable input (parity: control bit 7, channel: control bit 6) is 0, that latch is cleared on the next clock and ignores its source. Capture resumes when the input returns to 1, so a 1→0→1 toggle clears the latch.
- R8: The coprocessor request follows its input through two flip-flops. With delivery enabled, NMI rises three clocks after the input rises and falls three clocks after it falls, unless another request is pending.
- R9: The NMI output is a register holding the OR of all requests ANDed with the enable. It returns low once every request is cleared, so a later event produces a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | I/O write strobe |
| busAddr | input | 8 | I/O address |
| busData | input | 8 | I/O write data |
| parityErr | input | 1 | Memory parity error, active high, synchronous |
| chanChkN | input | 1 | Expansion-bus channel check, active low, asynchronous |
| copErr | input | 1 | Coprocessor interrupt line, active high |
| parityEn | input | 1 | Parity check enable from control bit 7 |
| chanEn | input | 1 | Channel check enable from control bit 6 |
| nmiOut | output | 1 | Registered NMI toward the processor |
| statParity | output | 1 | Parity latch state for status bit 7 |
| statChan | output | 1 | Channel latch state for status bit 6 |

## Verification
Assertions check several properties on every cycle. A disabled gate keeps NMI low on the following cycle. A held-low enable input empties its latch. A set latch with its enable input high stays set. A write to a foreign address leaves the delivery enable alone. Only the bench scenarios can show the exact latencies: the two-flop path of the channel and coprocessor inputs, NMI rising once delivery is enabled over a pending latch, the ignored data bits, and the clear-by-toggle sequence.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic wrEnable;   // load the delivery enable this cycle
    logic enValue;    // value to load
    logic parityHold; // hold parity latch in reset
    logic chanHold;   // hold channel latch in reset
  } nmi_ctrl_t;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= dIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl
  import nmi_gate_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hA0,
  parameter int                EN_BIT    = 7
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              parityEn,
  input  logic              chanEn,
  output nmi_ctrl_t         ctrl
);

  logic addrHit;

  assign addrHit = (busAddr == PORT_ADDR);

  always_comb begin
    ctrl            = '0;
    ctrl.wrEnable   = busWr && addrHit;
    ctrl.enValue    = busData[EN_BIT];
    ctrl.parityHold = !parityEn;
    ctrl.chanHold   = !chanEn;
  end

endmodule

// File: rtl/nmi_datapath.sv
module nmi_datapath
  import nmi_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  nmi_ctrl_t ctrl,
  input  logic      parityErr,
  input  logic      chanChkN,
  input  logic      copErr,
  output logic      nmiOut,
  output logic      statParity,
  output logic      statChan,
  output logic      enableOut
);

  localparam int N_SYNC = 2;

  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] syncOut;
  logic chanSeen;
  logic copReq;
  logic enableQ;
  logic parityLat;
  logic chanLat;
  logic nmiQ;
  logic anyReq;

  // Channel check is active low; fold both async lines into one synchroniser
  assign rawIn = {copErr, ~chanChkN};

  nmi_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_SYNC)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .dOut (syncOut)
  );

  assign chanSeen = syncOut[0];
  assign copReq   = syncOut[1];

  always_ff @(posedge clk) begin
    if (!rstN)              enableQ <= 1'b0;
    else if (ctrl.wrEnable) enableQ <= ctrl.enValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.parityHold) parityLat <= 1'b0;
    else if (parityErr)           parityLat <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.chanHold) chanLat <= 1'b0;
    else if (chanSeen)          chanLat <= 1'b1;
  end

  assign anyReq = parityLat | chanLat | copReq;

  always_ff @(posedge clk) begin
    if (!rstN) nmiQ <= 1'b0;
    else       nmiQ <= anyReq & enableQ;
  end

  assign nmiOut     = nmiQ;
  assign statParity = parityLat;
  assign statChan   = chanLat;
  assign enableOut  = enableQ;

  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !nmiOut);

  p_par_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (parityLat && !ctrl.parityHold) |=> parityLat);

  p_par_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.parityHold |=> !parityLat);

  p_chan_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.chanHold |=> !chanLat);

  p_chan_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanLat) |-> $past(chanSeen));

  p_nmi_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!parityLat && !chanLat && !copReq) |=> !nmiOut);

endmodule

// File: rtl/nmi_src_gate.sv
module nmi_src_gate
  import nmi_gate_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR   = 8'hA0,
  parameter int                EN_BIT      = 7,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              parityErr,
  input  logic              chanChkN,
  input  logic              copErr,
  input  logic              parityEn,
  input  logic              chanEn,
  output logic              nmiOut,
  output logic              statParity,
  output logic              statChan
);

  nmi_ctrl_t ctrl;
  logic      enable;

  nmi_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .EN_BIT(EN_BIT)
  ) u_ctrl (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busData  (busData),
    .parityEn (parityEn),
    .chanEn   (chanEn),
    .ctrl     (ctrl)
  );

  nmi_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .parityErr  (parityErr),
    .chanChkN   (chanChkN),
    .copErr     (copErr),
    .nmiOut     (nmiOut),
    .statParity (statParity),
    .statChan   (statChan),
    .enableOut  (enable)
  );

  p_foreign_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != PORT_ADDR) |=> $stable(enable));

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == PORT_ADDR) |=> (enable == $past(busData[EN_BIT])));

endmodule

// File: tb/nmi_src_gate_tb.sv
module nmi_src_gate_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busWr;
  logic [7:0] busAddr;
  logic [7:0] busData;
  logic       parityErr;
  logic       chanChkN;
  logic       copErr;
  logic       parityEn;
  logic       chanEn;
  logic       nmiOut;
  logic       statParity;
  logic       statChan;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  nmi_src_gate u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busData(busData),
    .parityErr(parityErr), .chanChkN(chanChkN), .copErr(copErr),
    .parityEn(parityEn), .chanEn(chanEn),
    .nmiOut(nmiOut), .statParity(statParity), .statChan(statChan)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one write; on return the enable register has been updated
  task automatic busWrite(input logic [7:0] addr, input logic [7:0] data);
    busWr = 1'b1; busAddr = addr; busData = data;
    tick();
    busWr = 1'b0; busAddr = 8'h00; busData = 8'h00;
  endtask

  task automatic clearAll();
    parityEn = 1'b0; chanEn = 1'b0;
    tick();
    parityEn = 1'b1; chanEn = 1'b1;
    busWrite(8'hA0, 8'h00);
    tick(3);
  endtask

  task automatic testReset();
    check(nmiOut, 1'b0, "R1 nmi after reset");
    check(statParity, 1'b0, "R1 parity status after reset");
    check(statChan, 1'b0, "R1 channel status after reset");
    parityErr = 1'b1; tick(); parityErr = 1'b0;
    tick(2);
    check(nmiOut, 1'b0, "R1 enable low after reset");
    clearAll();
  endtask

  task automatic testParityDisabled();
    parityErr = 1'b1; tick(); parityErr = 1'b0;
    check(statParity, 1'b1, "R4 parity latched");
    check(nmiOut, 1'b0, "R6 nmi held while disabled");
    tick(4);
    check(statParity, 1'b1, "R4 parity sticky");
    check(nmiOut, 1'b0, "R6 nmi still low");
    busWrite(8'hA0, 8'h80);
    check(nmiOut, 1'b0, "R6 nmi one cycle after enable");
    tick();
    check(nmiOut, 1'b1, "R6 nmi on enable with pending latch");
  endtask

  task automatic testClearToggle();
    parityEn = 1'b0; tick();
    check(statParity, 1'b0, "R7 parity cleared");
    tick();
    check(nmiOut, 1'b0, "R9 nmi returns low");
    parityErr = 1'b1; tick(); parityErr = 1'b0;
    check(statParity, 1'b0, "R7 source ignored while held");
    parityEn = 1'b1; tick(2);
    check(statParity, 1'b0, "R7 stays clear after toggle");
    check(nmiOut, 1'b0, "R7 nmi low after toggle");
    parityErr = 1'b1; tick(); parityErr = 1'b0;
    check(statParity, 1'b1, "R7 capture resumes");
    tick();
    check(nmiOut, 1'b1, "R9 new nmi after clear");
  endtask

  task automatic testEnableBits();
    busWrite(8'hA0, 8'h7F); tick();
    check(nmiOut, 1'b0, "R2 0x7F disables");
    busWrite(8'hA0, 8'hFF); tick();
    check(nmiOut, 1'b1, "R2 0xFF enables");
    busWrite(8'hA1, 8'h00); tick();
    check(nmiOut, 1'b1, "R3 write to 0xA1 ignored");
    busWrite(8'h20, 8'h00); tick();
    check(nmiOut, 1'b1, "R3 write to 0x20 ignored");
    clearAll();
  endtask

  task automatic testChannel();
    busWrite(8'hA0, 8'h80);
    chanChkN = 1'b0;
    tick();
    check(statChan, 1'b0, "R5 after one edge");
    tick();
    check(statChan, 1'b0, "R5 after two edges");
    tick();
    check(statChan, 1'b1, "R5 latched after three edges");
    check(nmiOut, 1'b0, "R5 nmi not yet");
    tick();
    check(nmiOut, 1'b1, "R5 nmi from channel");
    chanChkN = 1'b1; tick(5);
    check(statChan, 1'b1, "R5 channel sticky");
    check(statParity, 1'b0, "R5 parity untouched");
    chanEn = 1'b0; tick();
    check(statChan, 1'b0, "R7 channel cleared");
    chanEn = 1'b1; tick(2);
    check(nmiOut, 1'b0, "R7 nmi low after channel clear");
  endtask

  task automatic testCoprocessor();
    copErr = 1'b1;
    tick(2);
    check(nmiOut, 1'b0, "R8 cop after two edges");
    tick();
    check(nmiOut, 1'b1, "R8 cop nmi after three edges");
    parityErr = 1'b1; tick(); parityErr = 1'b0;
    copErr = 1'b0; tick(4);
    check(nmiOut, 1'b1, "R9 parity keeps nmi after cop drops");
    parityEn = 1'b0; tick(); parityEn = 1'b1; tick();
    check(nmiOut, 1'b0, "R9 nmi low with no request");
    copErr = 1'b1; tick(3);
    check(nmiOut, 1'b1, "R8 second cop rise");
    copErr = 1'b0; tick(2);
    check(nmiOut, 1'b1, "R8 still high two edges after drop");
    tick();
    check(nmiOut, 1'b0, "R8 cop drop clears nmi");
    busWrite(8'hA0, 8'h00);
    copErr = 1'b1; tick(5);
    check(nmiOut, 1'b0, "R6 cop gated while disabled");
    copErr = 1'b0; tick(3);
  endtask

  initial begin
    rstN = 1'b0; busWr = 1'b0; busAddr = 8'h00; busData = 8'h00;
    parityErr = 1'b0; chanChkN = 1'b1; copErr = 1'b0;
    parityEn = 1'b1; chanEn = 1'b1;
    tick(3);
    rstN = 1'b1;
    tick();
    testReset();
    testParityDisabled();
    testClearToggle();
    testEnableBits();
    testChannel();
    testCoprocessor();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule